// File: doc/BRIEF.md
# Dual-CPU Interrupt Source Controller

This block gathers interrupt events for two subordinate processors and gives each of them a 4-bit request level. Four event lines are shared by both processors: reset, vertical blank, horizontal blank and PWM. Each line is captured on its rising edge and stays pending until a processor clears it. Besides these, each processor has a private command interrupt. A host processor raises it with a single byte write, one bit per processor.

Each processor owns a 4-bit enable mask. It reaches the block through a shared register port that carries a processor id. Through that port it loads its mask, reads back a status word and acknowledges sources by writing to dedicated clear offsets. A clear of a shared source takes effect for both processors at once. A command clear affects only the writer's own command interrupt. A priority encoder turns each processor's enabled pending sources into a level number. The level is taken straight from the state registers, so it reflects a change on the cycle after the clock edge that recorded the change.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset, no source is pending, both masks are zero and both request levels are 0.
- R2: A host write to host offset 3 raises the command interrupt of processor 0 if data bit 0 is set, and of processor 1 if data bit 1 is set. A host write to any other offset has no effect. Raising a command that is already pending leaves the state unchanged.
- R3: A processor word write to offset 0x1a clears only that processor's command interrupt. A byte write to 0x1a has no effect.
- R4: Processor word writes to 0x14, 0x16, 0x18 and 0x1c clear the shared reset, vertical, horizontal and PWM sources. The clear applies to both processors, whichever processor writes.
- R5: A processor byte write to offset 1, or a word write to offset 0, loads that processor's mask from data bits 3:0. Mask bit 0 enables PWM, bit 1 command, bit 2 horizontal and bit 3 vertical. A byte write to offset 0 leaves the mask unchanged.
- R6: A read at offset 0 returns frame_mode in bit 15, a constant 1 in bit 9 and the mask of the processor selected by cpu_rd_id in bits 3:0, with all other bits 0. A read at any other offset returns 0.
- R7: src_in bits 0..3 carry the reset, vertical, horizontal and PWM events. A 0-to-1 transition sets the matching pending bit. An input held high after its bit has been cleared does not set the bit again.
- R8: A processor's level is 14 when reset is pending, whatever the mask. Otherwise it is the level of the highest-priority enabled pending source: vertical 12, horizontal 10, command 8, PWM 6. It is 0 when no enabled source is pending.
- R9: A change to a mask, a raise or a clear shows on the request level in the cycle right after the clock edge that records it.
- R10: When a source is set and cleared in the same cycle, it ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mode | input | 1 | Frame-mode flag reported in the status word |
| host_wr | input | 1 | Host byte-write strobe |
| host_addr | input | 6 | Host byte offset |
| host_wdata | input | 8 | Host write data |
| cpu_wr | input | 1 | Processor register write strobe |
| cpu_wr_word | input | 1 | 1 = word write, 0 = byte write |
| cpu_id | input | 1 | Id of the writing processor |
| cpu_addr | input | 8 | Processor write offset |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rd_id | input | 1 | Id of the reading processor |
| cpu_rd_addr | input | 8 | Processor read offset |
| cpu_rdata | output | 16 | Processor read data |
| src_in | input | 4 | Shared event lines (reset, vertical, horizontal, PWM) |
| irq_level | output | 8 | Request level per processor, 4 bits each, processor 0 in the low bits |

## Verification
The assertions watch the state registers on every cycle. They check that a host raise sets the command bit and that an own-command clear leaves the other processor's bit untouched. They also check that shared clears and rising edges move the pending bits, that mask loads take the written value, and that reset forces level 14 while an idle processor shows level 0. The full priority ordering under each mask, the readback word layout, the byte-versus-word decode, the no-relatch rule for a held-high input and set-beats-clear collisions can only be shown by the bench scenarios. Those scenarios compare both levels against a model after every step.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NUM_SHARED = 4;
  localparam int MASK_W     = 4;
  localparam int LVL_W      = 4;

  // shared source indices (src_in bit order)
  localparam int SRC_RESET = 0;
  localparam int SRC_VERT  = 1;
  localparam int SRC_HORZ  = 2;
  localparam int SRC_PWM   = 3;

  // mask bit positions
  localparam int MB_PWM  = 0;
  localparam int MB_CMD  = 1;
  localparam int MB_HORZ = 2;
  localparam int MB_VERT = 3;

  // request levels
  localparam logic [LVL_W-1:0] LVL_RESET = 4'd14;
  localparam logic [LVL_W-1:0] LVL_VERT  = 4'd12;
  localparam logic [LVL_W-1:0] LVL_HORZ  = 4'd10;
  localparam logic [LVL_W-1:0] LVL_CMD   = 4'd8;
  localparam logic [LVL_W-1:0] LVL_PWM   = 4'd6;
  localparam logic [LVL_W-1:0] LVL_NONE  = 4'd0;

  // processor register offsets
  localparam int OFF_STATUS  = 'h00;
  localparam int OFF_MASK_B  = 'h01;
  localparam int OFF_CLR_RST = 'h14;
  localparam int OFF_CLR_VRT = 'h16;
  localparam int OFF_CLR_HRZ = 'h18;
  localparam int OFF_CLR_CMD = 'h1a;
  localparam int OFF_CLR_PWM = 'h1c;

  // status word bit positions
  localparam int STAT_FM_BIT  = 15;
  localparam int STAT_AEN_BIT = 9;
endpackage

// File: rtl/irq_shared_latch.sv
module irq_shared_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] src_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar k = 0; k < N; k++) begin : g_src
    logic rise;
    assign rise = src_in[k] & ~src_q[k];
    // a new edge wins over a clear in the same cycle
    always_comb pend_d[k] = rise | (pend_q[k] & ~clr[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_in;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_ctl_pkg::*;
(
  input  logic [NUM_SHARED-1:0] shared_pend,
  input  logic                  cmd_pend,
  input  logic [MASK_W-1:0]     mask,
  output logic [LVL_W-1:0]      level
);
  always_comb begin
    level = LVL_NONE;
    if (shared_pend[SRC_RESET])
      level = LVL_RESET;
    else if (shared_pend[SRC_VERT] && mask[MB_VERT])
      level = LVL_VERT;
    else if (shared_pend[SRC_HORZ] && mask[MB_HORZ])
      level = LVL_HORZ;
    else if (cmd_pend && mask[MB_CMD])
      level = LVL_CMD;
    else if (shared_pend[SRC_PWM] && mask[MB_PWM])
      level = LVL_PWM;
  end
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
  import irq_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mask_we,
  input  logic [MASK_W-1:0]     mask_d,
  input  logic                  cmd_set,
  input  logic                  cmd_clr,
  input  logic [NUM_SHARED-1:0] shared_pend,
  output logic [MASK_W-1:0]     mask,
  output logic                  cmd_pend,
  output logic [LVL_W-1:0]      level
);
  logic [MASK_W-1:0] mask_q, mask_nx;
  logic              cmd_q, cmd_nx;

  always_comb begin
    mask_nx = mask_q;
    if (mask_we) mask_nx = mask_d;
    // raise wins over clear when both arrive together
    cmd_nx = cmd_set | (cmd_q & ~cmd_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cmd_q  <= 1'b0;
    end else begin
      mask_q <= mask_nx;
      cmd_q  <= cmd_nx;
    end
  end

  irq_prio_enc u_enc (
    .shared_pend (shared_pend),
    .cmd_pend    (cmd_q),
    .mask        (mask_q),
    .level       (level)
  );

  assign mask     = mask_q;
  assign cmd_pend = cmd_q;
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int N_CPU        = 2,
  parameter int HOST_AW      = 6,
  parameter int HOST_DW      = 8,
  parameter int CPU_AW       = 8,
  parameter int CPU_DW       = 16,
  parameter int HOST_CMD_OFF = 3,
  localparam int ID_W        = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_mode,
  input  logic                    host_wr,
  input  logic [HOST_AW-1:0]      host_addr,
  input  logic [HOST_DW-1:0]      host_wdata,
  input  logic                    cpu_wr,
  input  logic                    cpu_wr_word,
  input  logic [ID_W-1:0]         cpu_id,
  input  logic [CPU_AW-1:0]       cpu_addr,
  input  logic [CPU_DW-1:0]       cpu_wdata,
  input  logic [ID_W-1:0]         cpu_rd_id,
  input  logic [CPU_AW-1:0]       cpu_rd_addr,
  output logic [CPU_DW-1:0]       cpu_rdata,
  input  logic [NUM_SHARED-1:0]   src_in,
  output logic [N_CPU*LVL_W-1:0]  irq_level
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  // write decode
  logic                  host_cmd_hit;
  logic                  word_wr, byte_wr;
  logic [NUM_SHARED-1:0] shared_clr;
  logic                  cmd_clr_hit;

  assign host_cmd_hit = host_wr && (host_addr == HOST_AW'(HOST_CMD_OFF));
  assign word_wr      = cpu_wr &&  cpu_wr_word;
  assign byte_wr      = cpu_wr && !cpu_wr_word;
  assign cmd_clr_hit  = word_wr && (cpu_addr == CPU_AW'(OFF_CLR_CMD));

  always_comb begin
    shared_clr            = '0;
    shared_clr[SRC_RESET] = word_wr && (cpu_addr == CPU_AW'(OFF_CLR_RST));
    shared_clr[SRC_VERT]  = word_wr && (cpu_addr == CPU_AW'(OFF_CLR_VRT));
    shared_clr[SRC_HORZ]  = word_wr && (cpu_addr == CPU_AW'(OFF_CLR_HRZ));
    shared_clr[SRC_PWM]   = word_wr && (cpu_addr == CPU_AW'(OFF_CLR_PWM));
  end

  logic [NUM_SHARED-1:0] shared_pend;

  irq_shared_latch #(.N(NUM_SHARED)) u_shared (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .src_in (src_in),
    .clr    (shared_clr),
    .pend   (shared_pend)
  );

  logic [N_CPU*MASK_W-1:0] mask_flat;
  logic [N_CPU-1:0]        cmd_pend;

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    logic sel, mask_we;
    assign sel     = (cpu_id == ID_W'(g));
    assign mask_we = sel && ((word_wr && cpu_addr == CPU_AW'(OFF_STATUS)) ||
                             (byte_wr && cpu_addr == CPU_AW'(OFF_MASK_B)));

    irq_cpu_slice u_slice (
      .clk         (clk),
      .rst_n       (rst_n_sync),
      .mask_we     (mask_we),
      .mask_d      (cpu_wdata[MASK_W-1:0]),
      .cmd_set     (host_cmd_hit && host_wdata[g]),
      .cmd_clr     (cmd_clr_hit && sel),
      .shared_pend (shared_pend),
      .mask        (mask_flat[g*MASK_W +: MASK_W]),
      .cmd_pend    (cmd_pend[g]),
      .level       (irq_level[g*LVL_W +: LVL_W])
    );
  end

  // status readback
  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd_addr == CPU_AW'(OFF_STATUS)) begin
      cpu_rdata[STAT_FM_BIT]  = frame_mode;
      cpu_rdata[STAT_AEN_BIT] = 1'b1;
      cpu_rdata[MASK_W-1:0]   = mask_flat[int'(cpu_rd_id)*MASK_W +: MASK_W];
    end
  end

  logic unused_data;
  assign unused_data = ^{cpu_wdata[CPU_DW-1:MASK_W], host_wdata[HOST_DW-1:N_CPU]};
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
  import irq_ctl_pkg::*;
#(
  parameter int N_CPU        = 2,
  parameter int HOST_AW      = 6,
  parameter int HOST_DW      = 8,
  parameter int CPU_AW       = 8,
  parameter int CPU_DW       = 16,
  parameter int HOST_CMD_OFF = 3,
  parameter int ID_W         = 1
) (
  input logic                   clk,
  input logic                   rst_n_sync,
  input logic                   host_wr,
  input logic [HOST_AW-1:0]     host_addr,
  input logic [HOST_DW-1:0]     host_wdata,
  input logic                   cpu_wr,
  input logic                   cpu_wr_word,
  input logic [ID_W-1:0]        cpu_id,
  input logic [CPU_AW-1:0]      cpu_addr,
  input logic [CPU_DW-1:0]      cpu_wdata,
  input logic [NUM_SHARED-1:0]  src_in,
  input logic [NUM_SHARED-1:0]  shared_pend,
  input logic [N_CPU-1:0]       cmd_pend,
  input logic [N_CPU*MASK_W-1:0] mask_flat,
  input logic [N_CPU*LVL_W-1:0] irq_level
);
  logic host_cmd;
  assign host_cmd = host_wr && (host_addr == HOST_AW'(HOST_CMD_OFF));

  assert_src_edge_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (src_in[SRC_PWM] && !$past(src_in[SRC_PWM])) |=> shared_pend[SRC_PWM]);

  assert_vert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cpu_wr && cpu_wr_word && cpu_addr == CPU_AW'(OFF_CLR_VRT) && !src_in[SRC_VERT])
      |=> !shared_pend[SRC_VERT]);

  for (genvar g = 0; g < N_CPU; g++) begin : g_chk
    assert_cmd_raise_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (host_cmd && host_wdata[g]) |=> cmd_pend[g]);

    assert_cmd_clear_own_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (cpu_wr && cpu_wr_word && cpu_addr == CPU_AW'(OFF_CLR_CMD) &&
       cpu_id == ID_W'(g) && !(host_cmd && host_wdata[g])) |=> !cmd_pend[g]);

    assert_cmd_clear_other_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (cpu_wr && cpu_wr_word && cpu_addr == CPU_AW'(OFF_CLR_CMD) &&
       cpu_id != ID_W'(g) && !host_cmd) |=> $stable(cmd_pend[g]));

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (cpu_wr && cpu_id == ID_W'(g) &&
       ((cpu_wr_word && cpu_addr == CPU_AW'(OFF_STATUS)) ||
        (!cpu_wr_word && cpu_addr == CPU_AW'(OFF_MASK_B))))
      |=> mask_flat[g*MASK_W +: MASK_W] == $past(cpu_wdata[MASK_W-1:0]));

    assert_reset_top_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
      shared_pend[SRC_RESET] |-> irq_level[g*LVL_W +: LVL_W] == LVL_RESET);

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (shared_pend == '0 && !cmd_pend[g]) |-> irq_level[g*LVL_W +: LVL_W] == LVL_NONE);
  end
endmodule

bind irq_ctl_top irq_ctl_chk #(
  .N_CPU(N_CPU), .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .CPU_AW(CPU_AW),
  .CPU_DW(CPU_DW), .HOST_CMD_OFF(HOST_CMD_OFF), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .cpu_wr(cpu_wr), .cpu_wr_word(cpu_wr_word),
  .cpu_id(cpu_id), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .src_in(src_in),
  .shared_pend(shared_pend), .cmd_pend(cmd_pend), .mask_flat(mask_flat),
  .irq_level(irq_level)
);

// File: tb/tb_irq_ctl_top.sv
`timescale 1ns/1ps
module tb_irq_ctl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_mode;
  logic        host_wr;
  logic [5:0]  host_addr;
  logic [7:0]  host_wdata;
  logic        cpu_wr, cpu_wr_word;
  logic [0:0]  cpu_id, cpu_rd_id;
  logic [7:0]  cpu_addr, cpu_rd_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic [3:0]  src_in;
  logic [7:0]  irq_level;

  always #4 clk = ~clk;

  irq_ctl_top dut (
    .clk(clk), .rst_n(rst_n), .frame_mode(frame_mode),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .cpu_wr(cpu_wr), .cpu_wr_word(cpu_wr_word), .cpu_id(cpu_id),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd_id(cpu_rd_id),
    .cpu_rd_addr(cpu_rd_addr), .cpu_rdata(cpu_rdata), .src_in(src_in),
    .irq_level(irq_level)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  logic [3:0] m_sh;
  logic [1:0] m_cmd;
  logic [3:0] m_mask [2];
  logic [3:0] m_src_prev;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  function automatic logic [3:0] ref_level(input int c);
    if (m_sh[0])                        return 4'd14;
    else if (m_sh[1] && m_mask[c][3])   return 4'd12;
    else if (m_sh[2] && m_mask[c][2])   return 4'd10;
    else if (m_cmd[c] && m_mask[c][1])  return 4'd8;
    else if (m_sh[3] && m_mask[c][0])   return 4'd6;
    return 4'd0;
  endfunction

  // driver: apply one cycle of stimulus, update model, queue expected levels
  task automatic step(input logic hw, input logic [5:0] ha, input logic [7:0] hd,
                      input logic cw, input logic cword, input logic cid,
                      input logic [7:0] ca, input logic [15:0] cd,
                      input logic [3:0] src, input string tag);
    logic [3:0] rise, clr;
    @(negedge clk);
    host_wr = hw; host_addr = ha; host_wdata = hd;
    cpu_wr = cw; cpu_wr_word = cword; cpu_id = cid; cpu_addr = ca; cpu_wdata = cd;
    src_in = src;
    rise = src & ~m_src_prev;
    m_src_prev = src;
    clr[0] = cw && cword && ca == 8'h14;
    clr[1] = cw && cword && ca == 8'h16;
    clr[2] = cw && cword && ca == 8'h18;
    clr[3] = cw && cword && ca == 8'h1c;
    m_sh = rise | (m_sh & ~clr);
    for (int c = 0; c < 2; c++) begin
      logic set_c, clr_c;
      set_c = hw && ha == 6'd3 && hd[c];
      clr_c = cw && cword && ca == 8'h1a && cid == c[0];
      m_cmd[c] = set_c | (m_cmd[c] & ~clr_c);
      if (cw && cid == c[0] && ((cword && ca == 8'h00) || (!cword && ca == 8'h01)))
        m_mask[c] = cd[3:0];
    end
    @(posedge clk);
    #1;
    host_wr = 1'b0; cpu_wr = 1'b0;
    exp_q.push_back({ref_level(1), ref_level(0)});
    tag_q.push_back(tag);
  endtask

  task automatic host_w(input logic [5:0] a, input logic [7:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0, m_src_prev, tag);
  endtask

  task automatic cpu_w(input logic id, input logic word, input logic [7:0] a,
                       input logic [15:0] d, input string tag);
    step(1'b0, 6'd0, 8'h00, 1'b1, word, id, a, d, m_src_prev, tag);
  endtask

  task automatic set_src(input logic [3:0] s, input string tag);
    step(1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0, s, tag);
  endtask

  task automatic rd_check(input logic id, input logic [7:0] a, input string tag);
    logic [15:0] exp;
    @(negedge clk);
    cpu_rd_id = id; cpu_rd_addr = a;
    #1;
    exp = (a == 8'h00) ? {frame_mode, 5'b0, 1'b1, 5'b0, m_mask[id]} : 16'h0;
    checks++;
    if (cpu_rdata !== exp) begin
      failures++;
      $display("FAIL %s: cpu_rdata=%h expected %h", tag, cpu_rdata, exp);
    end
  endtask

  // monitor: compare levels one cycle after each driven step
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq_level !== e) begin
        failures++;
        $display("FAIL %s: irq_level=%h expected %h", t, irq_level, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_mode = 1'b1;
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    cpu_wr = 1'b0; cpu_wr_word = 1'b0; cpu_id = '0; cpu_addr = '0; cpu_wdata = '0;
    cpu_rd_id = '0; cpu_rd_addr = '0; src_in = '0;
    m_sh = '0; m_cmd = '0; m_mask[0] = '0; m_mask[1] = '0; m_src_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    set_src(4'b0000, "R1 reset levels");
    rd_check(1'b0, 8'h00, "R1 reset mask cpu0");
    rd_check(1'b1, 8'h00, "R1 reset mask cpu1");

    cpu_w(1'b0, 1'b0, 8'h01, 16'h000B, "R5 byte mask cpu0");
    rd_check(1'b0, 8'h00, "R6 status cpu0");
    cpu_w(1'b1, 1'b1, 8'h00, 16'h0006, "R5 word mask cpu1");
    rd_check(1'b1, 8'h00, "R6 status cpu1");
    rd_check(1'b1, 8'h02, "R6 other offset zero");
    cpu_w(1'b0, 1'b0, 8'h00, 16'h000F, "R5 byte at offset 0 ignored");
    rd_check(1'b0, 8'h00, "R5 mask unchanged");

    host_w(6'd3, 8'h01, "R2 raise cpu0");
    host_w(6'd2, 8'h03, "R2 wrong offset ignored");
    host_w(6'd3, 8'h02, "R2 raise cpu1");
    host_w(6'd3, 8'h03, "R2 repeat raise");

    set_src(4'b1000, "R7 pwm edge");
    set_src(4'b0000, "R7 pwm low");
    cpu_w(1'b0, 1'b1, 8'h1a, 16'h0, "R3 own command clear");
    cpu_w(1'b1, 1'b0, 8'h1a, 16'h0, "R3 byte clear ignored");

    set_src(4'b0100, "R8 horizontal");
    set_src(4'b0000, "R8 horizontal low");
    set_src(4'b0010, "R8 vertical");
    set_src(4'b0000, "R8 vertical low");
    cpu_w(1'b1, 1'b1, 8'h16, 16'h0, "R4 vertical clear shared");
    set_src(4'b0001, "R8 reset unmaskable");
    set_src(4'b0000, "R8 reset low");
    cpu_w(1'b0, 1'b1, 8'h14, 16'h0, "R4 reset clear");
    cpu_w(1'b0, 1'b1, 8'h18, 16'h0, "R4 horizontal clear");
    cpu_w(1'b1, 1'b1, 8'h1c, 16'h0, "R4 pwm clear");

    set_src(4'b0010, "R7 vertical held");
    cpu_w(1'b0, 1'b1, 8'h16, 16'h0, "R7 clear while held");
    set_src(4'b0010, "R7 no relatch while held");
    set_src(4'b0000, "R7 vertical release");

    step(1'b0, 6'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h1c, 16'h0, 4'b1000, "R10 edge beats clear");
    cpu_w(1'b1, 1'b1, 8'h1a, 16'h0, "R3 cpu1 clear");
    step(1'b1, 6'd3, 8'h02, 1'b1, 1'b1, 1'b1, 8'h1a, 16'h0, 4'b1000, "R10 raise beats clear");
    cpu_w(1'b0, 1'b0, 8'h01, 16'h0000, "R9 mask change re-evaluates");
    cpu_w(1'b0, 1'b0, 8'h01, 16'h0001, "R9 mask restore");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule